// File: doc/BRIEF.md
# Multi-Queue Ring Pointer Controller

This peripheral keeps a producer pointer and a consumer pointer for each of a set of hardware ring queues. Software never pushes or pops directly. It advances either pointer by writing a small increment to that queue's "advance" register. The block checks each advance against the ring's size, applies it modulo twice the ring size, and records any illegal request in sticky status flags.

Every queue has its own fixed address window. Inside the window there are two advance registers, two status words and a ring-size register. The status words return the pointers together with the sticky flags. Reading a status word clears the flags it returns. A per-queue non-empty output tells downstream consumers which rings hold work.

The register port is a simple single-cycle 32-bit interface. Read data is combinational from the current state. A read-to-clear takes effect on the clock edge that ends the access.

Top module: `ring_ptr_ctrl`

## Requirements
- R1: The queue index is address bits 18:11, so each queue window is 0x800 bytes. The offsets inside a window are: 0x0 advance consumer, 0x4 advance producer, 0x8 consumer status, 0xC producer status, 0x10 ring size. Unused offsets, and indexes at or above NUM_Q, read as 0, and writes to them change nothing.
- R2: The consumer status word holds the consumer pointer in bits 17:0, the bad-increment flag in bit 31 and the underflow flag in bit 30. The producer status word holds the producer pointer in bits 17:0 and the overflow flag in bit 30. All other bits read 0.
- R3: A producer advance by v (v ≤ 63) with fill + v ≤ 2^k moves the producer pointer to (p + v) mod 2^(k+1). Otherwise the pointer is unchanged and the overflow flag is set. Here fill = (producer − consumer) mod 2^(k+1).
- R4: A consumer advance by v (v ≤ 63) with v ≤ fill moves the consumer pointer modulo 2^(k+1). Otherwise the pointer is unchanged and the underflow flag is set.
- R5: An advance write with a value above 63, to either pointer, is dropped and sets the bad-increment flag. A value of exactly 63 is accepted.
- R6: The flags are sticky. Reading the consumer status word returns bits 31 and 30 and then clears both. Reading the producer status word returns bit 30 and then clears it.
- R7: The ring-size register holds k (ring size 2^k) in bits 4:0. A write of k ≤ 17 stores it and clears both pointers and all flags of that queue. A write above 17 is ignored.
- R8: q_not_empty[n] is 1 exactly when queue n's two pointers differ. It updates in the cycle after the write that changes them.
- R9: Reset clears all pointers and flags and sets every ring size to DEF_LOG2 (16 entries by default).
- R10: An access to one queue never changes the state of another queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | QSEL_W+WIN_SHIFT (19) | Byte address: queue index and window offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current access (combinational) |
| q_not_empty | output | NUM_Q | Per-queue non-empty indication |

## Verification
The hardest state to reach from the ports is a wrapped ring that is also full or over-drained. In that state the producer pointer is numerically below the consumer pointer, yet the fill level must still be computed correctly. The stimulus first shrinks a queue to four entries through its size register. It then advances both pointers in bounded steps until they cross the wrap point. Only then does it issue advances that just fit and advances that just exceed the limit, in both directions. A reference model in the bench follows every access, so the sticky flags and their clear-on-read can be compared after each step.

// File: rtl/ring_ptr_pkg.sv
package ring_ptr_pkg;
  localparam int PTR_W    = 18;
  localparam int WORD_W   = 32;
  localparam int MAX_INC  = 63;
  localparam int LOG2_W   = 5;
  localparam int MAX_LOG2 = PTR_W - 1;

  typedef enum logic [2:0] {
    REG_NONE, REG_ADV_CONS, REG_ADV_PROD, REG_STAT_CONS, REG_STAT_PROD, REG_SIZE
  } reg_kind_e;

  // Mask for pointer arithmetic modulo twice the ring size.
  function automatic logic [PTR_W-1:0] wrap_mask(input logic [LOG2_W-1:0] k);
    logic [PTR_W:0] t;
    t = ((PTR_W+1)'(1) << (k + LOG2_W'(1))) - (PTR_W+1)'(1);
    return t[PTR_W-1:0];
  endfunction

  function automatic logic [PTR_W:0] ring_len(input logic [LOG2_W-1:0] k);
    return (PTR_W+1)'(1) << k;
  endfunction

  function automatic logic [PTR_W-1:0] fill_level(input logic [PTR_W-1:0] prod,
                                                  input logic [PTR_W-1:0] cons,
                                                  input logic [LOG2_W-1:0] k);
    return (prod - cons) & wrap_mask(k);
  endfunction
endpackage

// File: rtl/ring_ptr_decode.sv
module ring_ptr_decode
  import ring_ptr_pkg::*;
#(
  parameter int NUM_Q     = 4,
  parameter int QSEL_W    = 8,
  parameter int WIN_SHIFT = 11
) (
  input  logic                        sel,
  input  logic [QSEL_W+WIN_SHIFT-1:0] addr,
  output logic [QSEL_W-1:0]           q_idx,
  output logic                        q_valid,
  output reg_kind_e                   kind
);
  localparam logic [WIN_SHIFT-1:0] OFF_ADV_CONS  = WIN_SHIFT'('h0);
  localparam logic [WIN_SHIFT-1:0] OFF_ADV_PROD  = WIN_SHIFT'('h4);
  localparam logic [WIN_SHIFT-1:0] OFF_STAT_CONS = WIN_SHIFT'('h8);
  localparam logic [WIN_SHIFT-1:0] OFF_STAT_PROD = WIN_SHIFT'('hC);
  localparam logic [WIN_SHIFT-1:0] OFF_SIZE      = WIN_SHIFT'('h10);

  logic [WIN_SHIFT-1:0] offset;

  assign q_idx   = addr[QSEL_W+WIN_SHIFT-1:WIN_SHIFT];
  assign offset  = addr[WIN_SHIFT-1:0];
  assign q_valid = (int'(q_idx) < NUM_Q);

  always_comb begin
    kind = REG_NONE;
    if (sel && q_valid) begin
      case (offset)
        OFF_ADV_CONS:  kind = REG_ADV_CONS;
        OFF_ADV_PROD:  kind = REG_ADV_PROD;
        OFF_STAT_CONS: kind = REG_STAT_CONS;
        OFF_STAT_PROD: kind = REG_STAT_PROD;
        OFF_SIZE:      kind = REG_SIZE;
        default:       kind = REG_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ring_ptr_queue.sv
module ring_ptr_queue
  import ring_ptr_pkg::*;
#(
  parameter int DEF_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_me,
  input  logic              we,
  input  reg_kind_e         kind,
  input  logic [WORD_W-1:0] wdata,
  output logic [PTR_W-1:0]  cons_ptr,
  output logic [PTR_W-1:0]  prod_ptr,
  output logic [LOG2_W-1:0] log2sz,
  output logic              flag_bad,
  output logic              flag_unf,
  output logic              flag_ovf,
  output logic              not_empty
);
  logic             do_cadv, do_padv, do_size, rd_cons, rd_prod;
  logic             inc_bad, size_ok;
  logic [PTR_W-1:0] inc, fill, mask;
  logic [PTR_W:0]   len;
  logic             ev_bad, ev_ovf, ev_unf, ev_cmove, ev_pmove, ev_resize;

  assign do_cadv = sel_me &&  we && (kind == REG_ADV_CONS);
  assign do_padv = sel_me &&  we && (kind == REG_ADV_PROD);
  assign do_size = sel_me &&  we && (kind == REG_SIZE);
  assign rd_cons = sel_me && !we && (kind == REG_STAT_CONS);
  assign rd_prod = sel_me && !we && (kind == REG_STAT_PROD);

  assign inc_bad = wdata > WORD_W'(MAX_INC);
  assign size_ok = wdata <= WORD_W'(MAX_LOG2);
  assign inc     = wdata[PTR_W-1:0];
  assign mask    = wrap_mask(log2sz);
  assign len     = ring_len(log2sz);
  assign fill    = fill_level(prod_ptr, cons_ptr, log2sz);

  // Named internal events
  assign ev_bad    = (do_cadv || do_padv) && inc_bad;
  assign ev_ovf    = do_padv && !inc_bad && (({1'b0, fill} + {1'b0, inc}) > len);
  assign ev_unf    = do_cadv && !inc_bad && (inc > fill);
  assign ev_pmove  = do_padv && !inc_bad && !ev_ovf;
  assign ev_cmove  = do_cadv && !inc_bad && !ev_unf;
  assign ev_resize = do_size && size_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cons_ptr <= '0;
      prod_ptr <= '0;
      log2sz   <= LOG2_W'(DEF_LOG2);
      flag_bad <= 1'b0;
      flag_unf <= 1'b0;
      flag_ovf <= 1'b0;
    end else if (ev_resize) begin
      log2sz   <= wdata[LOG2_W-1:0];
      cons_ptr <= '0;
      prod_ptr <= '0;
      flag_bad <= 1'b0;
      flag_unf <= 1'b0;
      flag_ovf <= 1'b0;
    end else begin
      if (ev_cmove) cons_ptr <= (cons_ptr + inc) & mask;
      if (ev_pmove) prod_ptr <= (prod_ptr + inc) & mask;
      if (ev_bad)       flag_bad <= 1'b1;
      else if (rd_cons) flag_bad <= 1'b0;
      if (ev_unf)       flag_unf <= 1'b1;
      else if (rd_cons) flag_unf <= 1'b0;
      if (ev_ovf)       flag_ovf <= 1'b1;
      else if (rd_prod) flag_ovf <= 1'b0;
    end
  end

  assign not_empty = (cons_ptr != prod_ptr);

  p_fill_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, fill} <= len);
  p_ptr_in_ring_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((prod_ptr & ~mask) == '0) && ((cons_ptr & ~mask) == '0));
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf |=> $stable(prod_ptr) && flag_ovf);
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unf |=> $stable(cons_ptr) && flag_unf);
  p_bad_inc_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad |=> $stable(cons_ptr) && $stable(prod_ptr) && flag_bad);
  p_prod_read_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_prod |=> !flag_ovf);
  p_cons_read_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cons |=> !flag_bad && !flag_unf);
  p_resize_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_resize |=> (cons_ptr == '0) && (prod_ptr == '0) && !flag_ovf);
endmodule

// File: rtl/ring_ptr_ctrl.sv
module ring_ptr_ctrl
  import ring_ptr_pkg::*;
#(
  parameter int NUM_Q     = 4,
  parameter int QSEL_W    = 8,
  parameter int WIN_SHIFT = 11,
  parameter int DEF_LOG2  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_sel,
  input  logic                        bus_we,
  input  logic [QSEL_W+WIN_SHIFT-1:0] bus_addr,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  output logic [NUM_Q-1:0]            q_not_empty
);
  localparam int QI_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;
  localparam int PAD  = WORD_W - 2 - PTR_W;

  logic [QSEL_W-1:0] q_idx;
  logic              q_valid;
  reg_kind_e         kind;
  logic [QI_W-1:0]   qi;

  logic [PTR_W-1:0]  cons_a [NUM_Q];
  logic [PTR_W-1:0]  prod_a [NUM_Q];
  logic [LOG2_W-1:0] size_a [NUM_Q];
  logic [NUM_Q-1:0]  bad_v, unf_v, ovf_v;

  ring_ptr_decode #(.NUM_Q(NUM_Q), .QSEL_W(QSEL_W), .WIN_SHIFT(WIN_SHIFT)) u_dec (
    .sel(bus_sel), .addr(bus_addr), .q_idx(q_idx), .q_valid(q_valid), .kind(kind)
  );

  assign qi = q_idx[QI_W-1:0];

  for (genvar g = 0; g < NUM_Q; g++) begin : g_q
    logic sel_me;
    assign sel_me = q_valid && (q_idx == QSEL_W'(g));
    ring_ptr_queue #(.DEF_LOG2(DEF_LOG2)) u_q (
      .clk(clk), .rst_n(rst_n), .sel_me(sel_me), .we(bus_we), .kind(kind),
      .wdata(bus_wdata), .cons_ptr(cons_a[g]), .prod_ptr(prod_a[g]),
      .log2sz(size_a[g]), .flag_bad(bad_v[g]), .flag_unf(unf_v[g]),
      .flag_ovf(ovf_v[g]), .not_empty(q_not_empty[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we && q_valid) begin
      case (kind)
        REG_STAT_CONS: bus_rdata = {bad_v[qi], unf_v[qi], {PAD{1'b0}}, cons_a[qi]};
        REG_STAT_PROD: bus_rdata = {1'b0, ovf_v[qi], {PAD{1'b0}}, prod_a[qi]};
        REG_SIZE:      bus_rdata = {{(WORD_W-LOG2_W){1'b0}}, size_a[qi]};
        default:       bus_rdata = '0;
      endcase
    end
  end

  p_oob_read_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && !q_valid) |-> (bus_rdata == '0));
endmodule

// File: tb/ring_ptr_ctrl_tb_top.sv
module ring_ptr_ctrl_tb_top;
  localparam int NQ = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [18:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NQ-1:0] q_not_empty;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_cons[NQ], m_prod[NQ], m_k[NQ];
  bit m_bad[NQ], m_unf[NQ], m_ovf[NQ];

  always #10 clk = ~clk;

  ring_ptr_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .q_not_empty(q_not_empty)
  );

  typedef struct packed {
    logic        we;
    logic [7:0]  q;
    logic [10:0] off;
    logic [31:0] data;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'd0, 11'h004, 32'd10},  '{1'b1, 8'd0, 11'h004, 32'd6},
    '{1'b0, 8'd0, 11'h00C, 32'd0},   '{1'b1, 8'd0, 11'h004, 32'd1},
    '{1'b0, 8'd0, 11'h00C, 32'd0},   '{1'b0, 8'd0, 11'h00C, 32'd0},
    '{1'b1, 8'd0, 11'h000, 32'd16},  '{1'b0, 8'd0, 11'h008, 32'd0},
    '{1'b1, 8'd2, 11'h004, 32'd63},  '{1'b1, 8'd2, 11'h010, 32'd6},
    '{1'b1, 8'd2, 11'h004, 32'd63},  '{1'b0, 8'd2, 11'h00C, 32'd0},
    '{1'b1, 8'd3, 11'h000, 32'd1},   '{1'b0, 8'd3, 11'h008, 32'd0},
    '{1'b1, 8'd1, 11'h004, 32'd64},  '{1'b0, 8'd1, 11'h008, 32'd0},
    '{1'b0, 8'd1, 11'h008, 32'd0},   '{1'b1, 8'd0, 11'h004, 32'd15},
    '{1'b1, 8'd0, 11'h000, 32'd15},  '{1'b0, 8'd0, 11'h00C, 32'd0},
    '{1'b1, 8'd0, 11'h004, 32'd5},   '{1'b0, 8'd0, 11'h00C, 32'd0},
    '{1'b0, 8'd0, 11'h010, 32'd0},   '{1'b1, 8'd5, 11'h004, 32'd3},
    '{1'b0, 8'd5, 11'h00C, 32'd0},   '{1'b0, 8'd0, 11'h014, 32'd0}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic int ring_mod(input int k);
    return 2 * (1 << k);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NQ; i++) begin
      m_cons[i] = 0; m_prod[i] = 0; m_k[i] = 4;
      m_bad[i] = 0; m_unf[i] = 0; m_ovf[i] = 0;
    end
  endtask

  task automatic model_write(input int q, input int off, input int data);
    int fill;
    if (q >= NQ) return;
    fill = (m_prod[q] - m_cons[q] + ring_mod(m_k[q])) % ring_mod(m_k[q]);
    if (off == 'h0 || off == 'h4) begin
      if (data > 63) m_bad[q] = 1;
      else if (off == 'h4) begin
        if (fill + data > (1 << m_k[q])) m_ovf[q] = 1;
        else m_prod[q] = (m_prod[q] + data) % ring_mod(m_k[q]);
      end else begin
        if (data > fill) m_unf[q] = 1;
        else m_cons[q] = (m_cons[q] + data) % ring_mod(m_k[q]);
      end
    end else if (off == 'h10 && data <= 17) begin
      m_k[q] = data; m_cons[q] = 0; m_prod[q] = 0;
      m_bad[q] = 0; m_unf[q] = 0; m_ovf[q] = 0;
    end
  endtask

  task automatic model_read(input int q, input int off, output int exp);
    exp = 0;
    if (q >= NQ) return;
    if (off == 'h8) begin
      exp = (int'(m_bad[q]) << 31) | (int'(m_unf[q]) << 30) | m_cons[q];
      m_bad[q] = 0; m_unf[q] = 0;
    end else if (off == 'hC) begin
      exp = (int'(m_ovf[q]) << 30) | m_prod[q];
      m_ovf[q] = 0;
    end else if (off == 'h10) exp = m_k[q];
  endtask

  function automatic logic [NQ-1:0] model_ne();
    logic [NQ-1:0] v;
    for (int i = 0; i < NQ; i++) v[i] = (m_cons[i] != m_prod[i]);
    return v;
  endfunction

  task automatic wr(input int q, input int off, input int data, input string tag);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = {q[7:0], off[10:0]}; bus_wdata = data;
    @(posedge clk); #1;
    bus_sel = 0; bus_we = 0;
    model_write(q, off, data);
    check(q_not_empty == model_ne(), {tag, "/R8 not_empty"}, int'(q_not_empty), int'(model_ne()));
  endtask

  task automatic rd(input int q, input int off, input string tag, output int val);
    int exp;
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = {q[7:0], off[10:0]};
    #2;
    val = bus_rdata;
    model_read(q, off, exp);
    check(val == exp, tag, val, exp);
    @(posedge clk); #1;
    bus_sel = 0;
  endtask

  function automatic string vec_tag(input vec_t v);
    if (int'(v.q) >= NQ || !(v.off inside {11'h0, 11'h4, 11'h8, 11'hC, 11'h10})) return "R1";
    if (v.off == 11'h10) return "R7";
    if (!v.we) return "R2";
    if (v.data > 63) return "R5";
    return (v.off == 11'h4) ? "R3" : "R4";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R9: reset state
    check(q_not_empty == '0, "R9 not_empty after reset", int'(q_not_empty), 0);
    for (int i = 0; i < NQ; i++) begin
      rd(i, 'h8, "R9 cons status", v);
      rd(i, 'hC, "R9 prod status", v);
      rd(i, 'h10, "R9 size", v);
      check(v == 4, "R9 default size literal", v, 4);
    end

    // Table walk against the reference model
    for (int n = 0; n < NV; n++) begin
      if (VECS[n].we) wr(int'(VECS[n].q), int'(VECS[n].off), int'(VECS[n].data), vec_tag(VECS[n]));
      else            rd(int'(VECS[n].q), int'(VECS[n].off), vec_tag(VECS[n]), v);
    end

    // R7/R3: shrink queue 1 to four entries and drive it across the wrap
    wr(1, 'h10, 2, "R7");
    wr(1, 'h4, 3, "R3");
    wr(1, 'h0, 3, "R4");
    wr(1, 'h4, 4, "R3 fill to full");
    rd(1, 'hC, "R3", v);
    check(v == 7, "R3 prod at 7", v, 7);
    wr(1, 'h0, 4, "R4");
    wr(1, 'h4, 3, "R3 wrap");
    rd(1, 'hC, "R3 wrap", v);
    check(v == 2, "R3 wrapped prod", v, 2);
    check(q_not_empty[1] == 1'b1, "R8 wrapped nonempty", int'(q_not_empty[1]), 1);
    wr(1, 'h4, 2, "R3 overflow");
    rd(1, 'hC, "R6 read ovf", v);
    check(v == 32'h4000_0002, "R3 overflow flag", v, 32'h4000_0002);
    rd(1, 'hC, "R6 cleared", v);
    check(v == 2, "R6 ovf cleared", v, 2);
    wr(1, 'h0, 4, "R4 underflow");
    rd(1, 'h8, "R4", v);
    check(v == 32'h4000_0007, "R4 underflow flag", v, 32'h4000_0007);
    wr(1, 'h0, 3, "R4 drain across wrap");
    check(q_not_empty[1] == 1'b0, "R8 drained", int'(q_not_empty[1]), 0);
    wr(1, 'h4, 64, "R5");
    rd(1, 'h8, "R5", v);
    check(v == 32'h8000_0002, "R5 bad flag", v, 32'h8000_0002);
    wr(1, 'h10, 18, "R7 invalid size");
    rd(1, 'h10, "R7", v);
    check(v == 2, "R7 invalid ignored", v, 2);

    // R5 boundary: 63 accepted
    wr(3, 'h10, 17, "R7");
    wr(3, 'h4, 63, "R5 max inc");
    rd(3, 'hC, "R5", v);
    check(v == 63, "R5 63 accepted", v, 63);

    // R10: back-to-back accesses on queue 2, then the other queues are compared
    wr(2, 'h0, 20, "R4 back-to-back");
    wr(2, 'h0, 20, "R4 back-to-back");
    wr(2, 'h4, 40, "R3 back-to-back");
    for (int i = 0; i < NQ; i++) begin
      rd(i, 'h8, "R10 cons", v);
      rd(i, 'hC, "R10 prod", v);
    end

    // R9: reset after activity
    @(negedge clk); rst_n = 0;
    @(posedge clk); #1 rst_n = 1;
    model_reset();
    check(q_not_empty == '0, "R9 not_empty after re-reset", int'(q_not_empty), 0);
    rd(3, 'hC, "R9 prod cleared", v);
    rd(1, 'h10, "R9 size restored", v);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule